// File: doc/BRIEF.md
# Offset Auto-Ranging Selector

This block picks the 3-bit offset code that the measurement front end applies while a channel is being digitised. The sixteen channels fall into five ranging groups and one calibration group. Group A covers channels 0 to 3, group B covers 4 to 7, and spares S1, S2 and S3 take channels 8, 9 and 10. Channels 11 to 15 are the calibration group. Each ranging group owns a small saturating up/down counter that forms the two low bits of its offset. The high bit always comes from the host offset register. When the averaged reading of a channel is latched, the latch pulse is steered to the group that owns the channel. The over-range or under-range flag that comes with the pulse then moves that group's counter by one code, and the new code is used on the group's next visit.

The calibration channels do not auto-range. They read a separate preset down-counter that the sequencing controller reloads at the start of a sweep and steps down between calibration readings. In manual mode the ranging counters ignore latch pulses. They are overwritten from the host offset register whenever the host signals new data. The block also reports the offset of every group, and the calibration count, for a status register.

Top module: `offs_autorange_sel`

## Requirements
- R1: While reset is asserted and right after it, every ranging counter is 0 and the calibration counter holds its preset, 3. Each group's reported offset is then its host high bit followed by 00.
- R2: A latch pulse changes only the counter of the group that owns `chan_i`: A for 0..3, B for 4..7, S1 for 8, S2 for 9, S3 for 10.
- R3: A latch pulse on channels 11..15 changes no ranging counter. For those channels `offs_sel_o` is 0 followed by the 2-bit calibration count.
- R4: In automatic mode, a latch pulse with over-range set and under-range clear raises the owning counter by one. A counter at 3 stays at 3.
- R5: In automatic mode, a latch pulse with under-range set and over-range clear lowers the owning counter by one. A counter at 0 stays at 0.
- R6: A latch pulse with both flags set or both clear leaves the counter unchanged. With no latch pulse, no counter moves in automatic mode.
- R7: In manual mode (`auto_mode_i`=0), latch pulses have no effect. A `host_load_i` pulse copies the two low bits of each group's host field into that group's counter.
- R8: In automatic mode, `host_load_i` has no effect on the counters.
- R9: Bit 2 of each group's offset always equals bit 2 of that group's host field. A change to it shows on the outputs in the same cycle.
- R10: `cal_preset_i` loads 3 into the calibration counter and takes priority over `cal_dec_i`. `cal_dec_i` alone lowers the counter by one, and it stays at 0 once it reaches 0.
- R11: `offs_sel_o` follows `chan_i` combinationally. A counter change made at a clock edge appears on the outputs after that edge.
- R12: Group g's host field and reported offset both sit at bits [3g+2:3g], with g = 0 A, 1 B, 2 S1, 3 S2, 4 S3. `cal_offs_o` carries the calibration count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_i | input | 4 | Channel being measured |
| latch_i | input | 1 | One-cycle pulse when the averaged reading is latched |
| over_i | input | 1 | Averaged reading above range |
| under_i | input | 1 | Averaged reading below range |
| auto_mode_i | input | 1 | 1 = automatic ranging, 0 = manual |
| host_load_i | input | 1 | Pulse: host offset register was rewritten |
| host_offs_i | input | 15 | Host offsets, 3 bits per group |
| cal_preset_i | input | 1 | Reload the calibration counter to 3 |
| cal_dec_i | input | 1 | Step the calibration counter down |
| offs_sel_o | output | 3 | Offset mux address for the current channel |
| grp_offs_o | output | 15 | Offsets in use per group, for status |
| cal_offs_o | output | 2 | Calibration counter value, for status |

## Verification
A wrong counter value is held until the owning group is next selected or reloaded. It is visible at once, however, in the status field `grp_offs_o`, because that field shows every group on every cycle. Mis-steering of a latch pulse moves a neighbouring group's field in the cycle after the pulse, while the intended group's field stays put. A wrap-around instead of saturation shows as a jump from 3 to 0 or from 0 to 3 in the cycle after a pulse. The reference model compares all three outputs on every clock, so each of these faults is caught within one cycle of its cause.

// File: rtl/offs_pkg.sv
package offs_pkg;
  localparam int CHAN_W    = 4;
  localparam int NUM_GRP   = 5;
  localparam int GRP_W     = $clog2(NUM_GRP + 1);
  localparam int CAL_FIRST = 11;

  typedef logic [CHAN_W-1:0] chan_t;
  typedef logic [GRP_W-1:0]  grp_t;

  localparam grp_t GRP_CAL = grp_t'(NUM_GRP);

  // channel -> ranging group; GRP_CAL for the calibration channels
  function automatic grp_t chan_to_grp(chan_t ch);
    grp_t g;
    if (ch <= chan_t'(3))       g = grp_t'(0);
    else if (ch <= chan_t'(7))  g = grp_t'(1);
    else if (ch == chan_t'(8))  g = grp_t'(2);
    else if (ch == chan_t'(9))  g = grp_t'(3);
    else if (ch == chan_t'(10)) g = grp_t'(4);
    else                        g = GRP_CAL;
    return g;
  endfunction
endpackage

// File: rtl/offs_ranger.sv
module offs_ranger #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_i,
  input  logic             latch_i,
  input  logic             over_i,
  input  logic             under_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MIN = '0;

  // one saturating step; opposing or absent requests hold
  function automatic logic [CNT_W-1:0] sat_step(logic [CNT_W-1:0] cur,
                                                logic up, logic dn);
    logic [CNT_W-1:0] r;
    r = cur;
    if (up && !dn && cur != CNT_MAX) r = cur + 1'b1;
    if (dn && !up && cur != CNT_MIN) r = cur - 1'b1;
    return r;
  endfunction

  logic             step_en;
  logic             step_up;
  logic             step_dn;
  logic             load_evt;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  assign step_en  = auto_i & latch_i;
  assign step_up  = step_en & over_i & ~under_i;
  assign step_dn  = step_en & under_i & ~over_i;
  assign load_evt = ~auto_i & load_i;

  always_comb begin
    if (load_evt) cnt_nxt = load_val_i;
    else          cnt_nxt = sat_step(cnt_q, step_up, step_dn);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_MIN;
    else        cnt_q <= cnt_nxt;
  end

  assign cnt_o = cnt_q;

  assert_sat_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);

  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> (int'(cnt_q) == int'($past(cnt_q))) ||
                (int'(cnt_q) == int'($past(cnt_q)) + 1) ||
                (int'(cnt_q) + 1 == int'($past(cnt_q))));

  assert_sat_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && cnt_q == CNT_MIN) |=> cnt_q == CNT_MIN);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && (over_i == under_i)) |=> $stable(cnt_q));

  assert_manual_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_i && !load_i) |=> $stable(cnt_q));

  assert_auto_no_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_i && !latch_i) |=> $stable(cnt_q));
endmodule

// File: rtl/offs_cal_cnt.sv
module offs_cal_cnt #(
  parameter int                CNT_W  = 2,
  parameter logic [CNT_W-1:0]  PRESET = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             preset_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o
);
  function automatic logic [CNT_W-1:0] dec_sat(logic [CNT_W-1:0] cur);
    return (cur == '0) ? cur : cur - 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             dec_evt;

  assign dec_evt = dec_i & ~preset_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= PRESET;
    else if (preset_i) cnt_q <= PRESET;
    else if (dec_evt)  cnt_q <= dec_sat(cnt_q);
  end

  assign cnt_o = cnt_q;

  assert_preset_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    preset_i |=> cnt_q == PRESET);

  assert_floor_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_evt && cnt_q == '0) |=> cnt_q == '0);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!preset_i && !dec_i) |=> $stable(cnt_q));
endmodule

// File: rtl/offs_steer.sv
module offs_steer
  import offs_pkg::*;
(
  input  logic               latch_i,
  input  chan_t              chan_i,
  output logic [NUM_GRP-1:0] grp_latch_o
);
  grp_t owner;
  assign owner = chan_to_grp(chan_i);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_route
    assign grp_latch_o[g] = latch_i & (owner == grp_t'(g));
  end
endmodule

// File: rtl/offs_autorange_sel.sv
module offs_autorange_sel
  import offs_pkg::*;
#(
  parameter int CNT_W      = 2,
  parameter int OFFS_W     = 3,
  parameter int CAL_PRESET = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CHAN_W-1:0]           chan_i,
  input  logic                        latch_i,
  input  logic                        over_i,
  input  logic                        under_i,
  input  logic                        auto_mode_i,
  input  logic                        host_load_i,
  input  logic [NUM_GRP*OFFS_W-1:0]   host_offs_i,
  input  logic                        cal_preset_i,
  input  logic                        cal_dec_i,
  output logic [OFFS_W-1:0]           offs_sel_o,
  output logic [NUM_GRP*OFFS_W-1:0]   grp_offs_o,
  output logic [CNT_W-1:0]            cal_offs_o
);
  localparam int HI_W = OFFS_W - CNT_W;

  logic [NUM_GRP-1:0]       grp_latch;
  logic [NUM_GRP*OFFS_W-1:0] grp_offs;
  logic [CNT_W-1:0]         cal_cnt;
  grp_t                     sel_grp;

  offs_steer u_steer (
    .latch_i     (latch_i),
    .chan_i      (chan_i),
    .grp_latch_o (grp_latch)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [CNT_W-1:0] cnt;
    offs_ranger #(.CNT_W(CNT_W)) u_rng (
      .clk        (clk),
      .rst_n      (rst_n),
      .auto_i     (auto_mode_i),
      .latch_i    (grp_latch[g]),
      .over_i     (over_i),
      .under_i    (under_i),
      .load_i     (host_load_i),
      .load_val_i (host_offs_i[g*OFFS_W +: CNT_W]),
      .cnt_o      (cnt)
    );
    assign grp_offs[g*OFFS_W +: OFFS_W] =
      {host_offs_i[g*OFFS_W + CNT_W +: HI_W], cnt};
  end

  offs_cal_cnt #(.CNT_W(CNT_W), .PRESET(CNT_W'(CAL_PRESET))) u_cal (
    .clk      (clk),
    .rst_n    (rst_n),
    .preset_i (cal_preset_i),
    .dec_i    (cal_dec_i),
    .cnt_o    (cal_cnt)
  );

  assign sel_grp = chan_to_grp(chan_i);

  always_comb begin
    offs_sel_o = {{HI_W{1'b0}}, cal_cnt};
    for (int g = 0; g < NUM_GRP; g++) begin
      if (sel_grp == grp_t'(g)) offs_sel_o = grp_offs[g*OFFS_W +: OFFS_W];
    end
  end

  assign grp_offs_o = grp_offs;
  assign cal_offs_o = cal_cnt;

  assert_steer_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_latch));

  assert_group_a_gets_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_i && chan_i <= CHAN_W'(3)) |-> grp_latch[0]);

  assert_cal_no_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_i >= CHAN_W'(CAL_FIRST)) |-> grp_latch == '0);
endmodule

// File: tb/offs_autorange_sel_tb.sv
`timescale 1ns/1ps
module offs_autorange_sel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  chan = 4'd0;
  logic        latch = 1'b0, over = 1'b0, under = 1'b0;
  logic        auto_m = 1'b1, hload = 1'b0;
  logic [14:0] host = 15'h568E;
  logic        cpre = 1'b0, cdec = 1'b0;
  logic [2:0]  sel;
  logic [14:0] gofs;
  logic [1:0]  cofs;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  offs_autorange_sel dut_i (
    .clk(clk), .rst_n(rst_n), .chan_i(chan), .latch_i(latch), .over_i(over),
    .under_i(under), .auto_mode_i(auto_m), .host_load_i(hload),
    .host_offs_i(host), .cal_preset_i(cpre), .cal_dec_i(cdec),
    .offs_sel_o(sel), .grp_offs_o(gofs), .cal_offs_o(cofs));

  // ---------------- reference model ----------------
  int gc[5];
  int cc = 3;

  function automatic int owner(int ch);
    if (ch < 4) return 0;
    if (ch < 8) return 1;
    if (ch < 11) return ch - 6;
    return 5;
  endfunction

  function automatic int hi_bit(int g);
    return (int'(host) >> (3 * g + 2)) & 1;
  endfunction

  function automatic int m_status();
    int s = 0;
    for (int g = 0; g < 5; g++) s += ((hi_bit(g) * 4) + gc[g]) << (3 * g);
    return s;
  endfunction

  function automatic int m_sel(int ch);
    int g = owner(ch);
    if (g == 5) return cc;
    return hi_bit(g) * 4 + gc[g];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < 5; g++) gc[g] = 0;
      cc = 3;
    end else begin
      for (int g = 0; g < 5; g++) begin
        if (auto_m) begin
          if (latch && owner(int'(chan)) == g) begin
            if (over && !under && gc[g] < 3) gc[g]++;
            else if (under && !over && gc[g] > 0) gc[g]--;
          end
        end else if (hload) begin
          gc[g] = (int'(host) >> (3 * g)) & 3;
        end
      end
      if (cpre) cc = 3;
      else if (cdec && cc > 0) cc--;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R11 offs_sel vs model", int'(sel), m_sel(int'(chan)));
      chk("R12 grp_offs vs model", int'(gofs), m_status());
      chk("R10 cal_offs vs model", int'(cofs), cc);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drv(int ch, bit l, bit o, bit u);
    @(negedge clk);
    chan = 4'(ch); latch = l; over = o; under = u;
    hload = 1'b0; cpre = 1'b0; cdec = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    latch = 1'b0; over = 1'b0; under = 1'b0;
    hload = 1'b0; cpre = 1'b0; cdec = 1'b0;
    #1;
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    chan = 4'd11;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state, host high bits set for A and S3
    chk("R1 grp_offs in reset", int'(gofs), 16388);
    chk("R1 cal in reset", int'(cofs), 3);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 grp_offs after reset", int'(gofs), 16388);
    chk("R1 sel on cal channel", int'(sel), 3);

    // R4: four over-range latches on channel 2 saturate group A at 3
    repeat (4) drv(2, 1, 1, 0);
    settle();
    chk("R4 group A saturates at 3", int'(gofs) & 7, 7);
    chk("R2 other groups untouched", int'(gofs) >> 3, 2048);

    // R5: five under-range latches bring group A to 0 and hold there
    repeat (5) drv(1, 1, 0, 1);
    settle();
    chk("R5 group A floors at 0", int'(gofs) & 7, 4);

    // R6: both flags, or flag without latch
    repeat (2) drv(3, 1, 1, 1);
    drv(3, 0, 1, 0);
    settle();
    chk("R6 no step on conflict or no latch", int'(gofs) & 7, 4);

    // R2: channel 9 belongs to S2
    repeat (2) drv(9, 1, 1, 0);
    settle();
    chk("R2 S2 field stepped to 2", (int'(gofs) >> 9) & 7, 2);
    chk("R2 group A unchanged", int'(gofs) & 7, 4);

    // R3: calibration channel latch changes nothing
    repeat (3) drv(13, 1, 1, 0);
    settle();
    chk("R3 status unchanged on cal latch", int'(gofs), 16388 + (2 << 9));
    chk("R3 sel on cal channel", int'(sel), 3);

    // R8: host load ignored in automatic mode
    @(negedge clk); hload = 1'b1;
    settle();
    chk("R8 auto ignores host load", int'(gofs), 16388 + (2 << 9));

    // R7: manual mode ignores latches, loads on host pulse
    @(negedge clk); auto_m = 1'b0;
    repeat (2) drv(2, 1, 1, 0);
    settle();
    chk("R7 manual ignores latch", int'(gofs), 16388 + (2 << 9));
    @(negedge clk); hload = 1'b1;
    settle();
    chk("R7 manual load copies host", int'(gofs), 22158);
    chk("R12 field packing equals host", int'(gofs), int'(host));

    // R9: high bit follows host in the same cycle
    @(negedge clk); chan = 4'd5; host[5] = 1'b1;
    #1;
    chk("R9 high bit follows host", int'(sel), 5);

    // R10: calibration count down and preset priority
    repeat (4) begin @(negedge clk); cdec = 1'b1; end
    settle();
    chk("R10 cal floors at 0", int'(cofs), 0);
    @(negedge clk); cpre = 1'b1; cdec = 1'b1;
    settle();
    chk("R10 preset wins over decrement", int'(cofs), 3);
    @(negedge clk); cdec = 1'b1;
    settle();
    chk("R10 single decrement", int'(cofs), 2);

    // R11: change appears only after the edge
    @(negedge clk); auto_m = 1'b1; chan = 4'd0; latch = 1'b1; over = 1'b1;
    #1;
    chk("R11 sel before edge", int'(sel), 6);
    settle();
    chk("R11 sel after edge", int'(sel), 7);

    // mixed random traffic, checked every cycle by the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      chan   = 4'($urandom_range(0, 15));
      latch  = 1'($urandom_range(0, 1));
      over   = 1'($urandom_range(0, 1));
      under  = 1'($urandom_range(0, 1));
      hload  = ($urandom_range(0, 7) == 0);
      cpre   = ($urandom_range(0, 15) == 0);
      cdec   = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 63) == 0) auto_m = ~auto_m;
      if ($urandom_range(0, 31) == 0) host = 15'($urandom);
    end
    settle();
    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule